// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Ready Flags

This block moves 18-bit words from a write-clock domain to an independent read-clock domain. Storage is a 1024-entry dual-port array followed by a single output register, so the queue holds up to 1025 words. The write side accepts a word when both of its enables are high and its ready flag is set. The read side holds the oldest word in the output register and flags it as ready. A read consumes that word only when the output enable and both read enables are high.

Each pointer crosses to the other domain as a Gray code through a two-flop synchronizer. This gives every flag a fixed latency, counted in edges of the receiving clock. When the FIFO is empty, a newly written word falls through to the output register on its own; no read enable is needed for that. The data output is released to high impedance whenever the output enable is low.

One active-low reset clears both domains. The reset is sampled synchronously in each domain and must be held for at least four cycles of each clock.

Top module: `dcf_fifo`

## Requirements
- R1: A word is stored on a wr_clk rising edge only when in_ready, wr_en_a and wr_en_b are all high. A write attempt with either enable low, or with in_ready low, stores nothing and never reaches the output.
- R2: A word is consumed on a rd_clk rising edge only when out_ready, out_en, rd_en_a and rd_en_b are all high. Otherwise out_ready and the presented word hold.
- R3: When the FIFO is empty, the first word written appears on rd_data, with out_ready high, on the third rd_clk edge after the write edge. This happens whatever the read enables are doing.
- R4: out_ready falls on the read edge that consumes the last held word, and at no other time outside reset.
- R5: The FIFO holds at most 1025 words: 1024 in the array plus one in the output register. With no reads, exactly 1025 writes are accepted before in_ready stays low.
- R6: After a full condition, in_ready rises on the second wr_clk edge after the read edge that frees space.
- R7: When rst_n is held low for at least four cycles of each clock, in_ready and out_ready go low and all held words are discarded.
- R8: After rst_n is released, in_ready rises on the second wr_clk edge. The first edge that samples rst_n high counts as edge one.
- R9: rd_data is high impedance whenever out_en is low.
- R10: Words leave in the order they were written, with their values unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| wr_clk | input | 1 | Write-domain clock |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | 18 | Word to store |
| in_ready | output | 1 | Space available; a write is accepted while high |
| rd_clk | input | 1 | Read-domain clock |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable; also gates reads |
| rd_data | output | 18 | Oldest held word, high impedance while out_en is low |
| out_ready | output | 1 | A valid word is in the output register |

## Verification
A corrupted write pointer appears at the ports as a duplicated or missing word in the read stream. It also shifts the accept count when the FIFO is filled, so it is seen no later than the fill or drain that follows. A wrong synchronizer depth, or a wrong startup qualifier, moves the edge on which out_ready or in_ready changes; the per-edge comparison catches this on the first transfer after reset or after a full condition. An output register that reloads or drops a word without a valid read shows on rd_data within one read edge.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    // Default geometry of the FIFO.
    localparam int DCF_WIDTH = 18;
    localparam int DCF_DEPTH = 1024;
    localparam int DCF_SYNC  = 2;

    // Pointer width: one wrap bit above the array address.
    function automatic int ptr_width(input int depth);
        return $clog2(depth) + 1;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer.
// Assumes the input changes by at most one bit per source edge.
module dcf_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pointer through the stages; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_gray2bin.sv
// Combinational conversion from Gray code to binary.
module dcf_gray2bin #(
    parameter int W = 11
) (
    input  logic [W-1:0] g,
    output logic [W-1:0] b
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign b[i] = ^g[W-1:i];
        end
    endgenerate
endmodule

// File: rtl/dcf_ram.sv
// Dual-port word array with a registered read port.
// The read register is the output stage of the FIFO.
// Assumes the same address is never written and loaded in the same cycle.
module dcf_ram #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic             wr_clk,
    input  logic             wr_fire,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_clk,
    input  logic             load,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] word
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[waddr] <= wdata;
    end

    // Move the oldest array word into the output register.
    always_ff @(posedge rd_clk) begin
        if (load) word <= mem[raddr];
    end
endmodule

// File: rtl/dcf_wr_side.sv
// Write-domain control: write pointer, startup qualifier and input-ready.
// Assumes rptr_gray_sync is already synchronized into wr_clk.
module dcf_wr_side #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int PW    = 11
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          en_a,
    input  logic          en_b,
    input  logic [PW-1:0] rptr_gray_sync,
    output logic          in_ready,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wptr_gray,
    output logic [PW-1:0] wptr_bin
);
    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    logic [PW-1:0] wptr, wptr_nxt, rbin, occ;
    logic [1:0]    live;

    dcf_gray2bin #(.W(PW)) u_r2b (.g(rptr_gray_sync), .b(rbin));

    assign occ      = wptr - rbin;
    assign in_ready = live[1] && (occ < CAP);
    assign wr_fire  = in_ready & en_a & en_b;
    assign wptr_nxt = wptr + {{(PW-1){1'b0}}, wr_fire};
    assign waddr    = wptr[AW-1:0];
    assign wptr_bin = wptr;

    // Advance the pointer, publish its Gray form, and qualify the start.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wptr      <= '0;
            wptr_gray <= '0;
            live      <= 2'b00;
        end else begin
            wptr      <= wptr_nxt;
            wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
            live      <= {live[0], 1'b1};
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
// Read-domain control: read pointer, output-register load and output-ready.
// Assumes wptr_gray_sync is already synchronized into rd_clk.
module dcf_rd_side #(
    parameter int AW = 10,
    parameter int PW = 11
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          en_a,
    input  logic          en_b,
    input  logic          out_en,
    input  logic [PW-1:0] wptr_gray_sync,
    output logic          out_ready,
    output logic          load,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rptr_gray,
    output logic [PW-1:0] rptr_bin
);
    logic [PW-1:0] rptr, rptr_nxt, wbin;
    logic          avail, take;

    dcf_gray2bin #(.W(PW)) u_w2b (.g(wptr_gray_sync), .b(wbin));

    assign avail    = (wbin != rptr);
    assign take     = out_ready & out_en & en_a & en_b;
    assign load     = avail & (~out_ready | take);
    assign rptr_nxt = rptr + {{(PW-1){1'b0}}, load};
    assign raddr    = rptr[AW-1:0];
    assign rptr_bin = rptr;

    // Track the read pointer and whether the output register holds a word.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rptr      <= '0;
            rptr_gray <= '0;
            out_ready <= 1'b0;
        end else begin
            rptr      <= rptr_nxt;
            rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
            if (load)      out_ready <= 1'b1;
            else if (take) out_ready <= 1'b0;
        end
    end
endmodule

// File: rtl/dcf_fifo.sv
// Dual-clock FIFO top: array plus output register, Gray pointers crossing
// through synchronizers. Assumes DEPTH is a power of two and that rst_n is
// held low for at least four cycles of each clock.
module dcf_fifo #(
    parameter int WIDTH = dcf_pkg::DCF_WIDTH,
    parameter int DEPTH = dcf_pkg::DCF_DEPTH,
    parameter int SYNC  = dcf_pkg::DCF_SYNC
) (
    input  logic             rst_n,
    input  logic             wr_clk,
    input  logic             wr_en_a,
    input  logic             wr_en_b,
    input  logic [WIDTH-1:0] wr_data,
    output logic             in_ready,
    input  logic             rd_clk,
    input  logic             rd_en_a,
    input  logic             rd_en_b,
    input  logic             out_en,
    output wire  [WIDTH-1:0] rd_data,
    output logic             out_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = dcf_pkg::ptr_width(DEPTH);

    logic             wr_fire, load;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s, w_ptr_bin, r_ptr_bin;
    logic [WIDTH-1:0] out_word;

    dcf_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .en_a(wr_en_a), .en_b(wr_en_b),
        .rptr_gray_sync(rgray_s), .in_ready(in_ready), .wr_fire(wr_fire),
        .waddr(waddr), .wptr_gray(wgray), .wptr_bin(w_ptr_bin)
    );

    dcf_rd_side #(.AW(AW), .PW(PW)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .en_a(rd_en_a), .en_b(rd_en_b),
        .out_en(out_en), .wptr_gray_sync(wgray_s), .out_ready(out_ready),
        .load(load), .raddr(raddr), .rptr_gray(rgray), .rptr_bin(r_ptr_bin)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .wr_clk(wr_clk), .wr_fire(wr_fire), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .load(load), .raddr(raddr), .word(out_word)
    );

    // Release the output bus while the output enable is low.
    assign rd_data = out_en ? out_word : {WIDTH{1'bz}};
endmodule

// File: rtl/dcf_fifo_chk.sv
// Property checker for dcf_fifo, attached through bind.
module dcf_fifo_chk #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 1024,
    parameter int PW    = 11
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_ready,
    input logic             wr_en_a,
    input logic             wr_en_b,
    input logic             rd_en_a,
    input logic             rd_en_b,
    input logic             out_en,
    input logic [PW-1:0]    w_ptr,
    input logic [PW-1:0]    r_ptr,
    input logic [WIDTH-1:0] word
);
    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    logic [PW-1:0] held;
    assign held = w_ptr - r_ptr;

    // R1: a refused write leaves the write pointer unchanged.
    a_r1_refused_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(in_ready && wr_en_a && wr_en_b) |=> $stable(w_ptr));

    // R5: the array never holds more than its depth.
    a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        held <= CAP);

    // R2: without a full read qualification the presented word holds.
    a_r2_hold_word: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (out_ready && !(out_en && rd_en_a && rd_en_b)) |=> (out_ready && $stable(word)));

    // R4: out_ready only falls after a qualified read.
    a_r4_fall_on_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(out_ready) |-> $past(out_en && rd_en_a && rd_en_b));
endmodule

bind dcf_fifo dcf_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .in_ready(in_ready),
    .out_ready(out_ready), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
    .w_ptr(w_ptr_bin), .r_ptr(r_ptr_bin), .word(out_word)
);

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
    localparam int W     = 18;
    localparam int DEPTH = 1024;
    localparam int CAPT  = DEPTH + 1;

    logic clk = 1'b0;
    logic rst_n, wa, wb, ra, rb, oe;
    logic [W-1:0] wd;
    logic in_ready, out_ready;
    wire  [W-1:0] rd_bus;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    // Weak pull so a released bus reads as all ones.
    for (genvar i = 0; i < W; i++) begin : g_pu
        pullup pu (rd_bus[i]);
    end

    dcf_fifo u_dut (
        .rst_n(rst_n), .wr_clk(clk), .wr_en_a(wa), .wr_en_b(wb), .wr_data(wd),
        .in_ready(in_ready), .rd_clk(clk), .rd_en_a(ra), .rd_en_b(rb),
        .out_en(oe), .rd_data(rd_bus), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model: queue of words plus delayed counts.
    int mq[$];
    int wcnt, pcnt, wd1, wd2, pd1, pd2, odata;
    bit lv0, lv1, ov;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            wcnt = 0; pcnt = 0; wd1 = 0; wd2 = 0; pd1 = 0; pd2 = 0;
            lv0 = 0; lv1 = 0; ov = 0;
        end else begin
            automatic bit m_in  = lv1 && ((wcnt - pd2) < DEPTH);
            automatic bit do_w  = m_in && wa && wb;
            automatic bit do_r  = ov && oe && ra && rb;
            automatic bit avail = pcnt < wd2;
            automatic int ow = wcnt;
            automatic int op = pcnt;
            if (do_w) begin
                mq.push_back(int'(wd));
                wcnt++;
            end
            if (!ov || do_r) begin
                if (avail) begin
                    odata = mq.pop_front();
                    ov = 1;
                    pcnt++;
                end else begin
                    ov = 0;
                end
            end
            wd2 = wd1; wd1 = ow; pd2 = pd1; pd1 = op;
            lv1 = lv0; lv0 = 1;
        end
    end

    // Compare the ports with the model one ns after every edge.
    always @(posedge clk) begin
        #1;
        begin
            automatic bit exp_in = lv1 && ((wcnt - pd2) < DEPTH);
            chk(in_ready == exp_in, "R5 R6 R8 in_ready", int'(in_ready), int'(exp_in));
            chk(out_ready == ov, "R2 R3 R4 out_ready", int'(out_ready), int'(ov));
            if (oe && ov)
                chk(int'(rd_bus) == odata, "R10 R1 rd_data", int'(rd_bus), odata);
            if (!oe)
                chk(rd_bus == {W{1'b1}}, "R9 released bus", int'(rd_bus), (1 << W) - 1);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n, acc, reads;
        rst_n = 0; wa = 0; wb = 0; ra = 0; rb = 0; oe = 0; wd = '0;
        repeat (4) @(negedge clk);
        chk(!in_ready && !out_ready, "R7 flags after reset", int'({in_ready, out_ready}), 0);

        // R8: startup latency of in_ready.
        rst_n = 1;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!in_ready && n < 10);
        chk(n == 2, "R8 edges to in_ready", n, 2);

        // R3: fall-through of the first word, read enables low.
        @(negedge clk); wa = 1; wb = 1; wd = 18'h0A5A5;
        @(negedge clk); wa = 0; wb = 0;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!out_ready && n < 10);
        chk(n == 3, "R3 edges to out_ready", n, 3);
        chk(rd_bus == {W{1'b1}}, "R9 bus released", int'(rd_bus), (1 << W) - 1);
        @(negedge clk); oe = 1; #1;
        chk(rd_bus == 18'h0A5A5, "R3 first word", int'(rd_bus), 'h0A5A5);

        // R2: partial read enables hold the word.
        ra = 1; rb = 0;
        repeat (5) @(negedge clk);
        ra = 0; rb = 1;
        repeat (3) @(negedge clk);
        chk(out_ready && rd_bus == 18'h0A5A5, "R2 word held", int'(rd_bus), 'h0A5A5);

        // R4: consume the only word.
        ra = 1; rb = 1;
        @(negedge clk); ra = 0; rb = 0;
        chk(!out_ready, "R4 out_ready after last read", int'(out_ready), 0);

        // R1: a write with one enable low is dropped.
        wa = 1; wb = 0; wd = 18'h11111;
        repeat (3) @(negedge clk);
        wa = 0; wb = 1;
        repeat (3) @(negedge clk);
        wb = 0;
        repeat (6) @(negedge clk);
        chk(!out_ready, "R1 refused writes absent", int'(out_ready), 0);

        // R5: fill without reads, count accepted writes.
        acc = 0; wa = 1; wb = 1;
        for (int i = 0; i < 1100; i++) begin
            wd = W'(acc + 18'h100);
            if (in_ready) acc++;
            @(negedge clk);
        end
        wa = 0; wb = 0;
        chk(acc == CAPT, "R5 accepted words", acc, CAPT);
        chk(!in_ready, "R5 in_ready when full", int'(in_ready), 0);

        // R6: one read frees space; in_ready returns after two edges.
        repeat (3) @(negedge clk);
        ra = 1; rb = 1;
        @(negedge clk); ra = 0; rb = 0;
        chk(!in_ready, "R6 in_ready right after read", int'(in_ready), 0);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!in_ready && n < 10);
        chk(n == 2, "R6 edges to in_ready", n, 2);

        // R10 and R4: drain in order, out_ready drops after the last word.
        @(negedge clk);
        reads = 1; ra = 1; rb = 1;
        for (int i = 0; i < 1200 && out_ready; i++) begin
            reads++;
            @(negedge clk);
        end
        ra = 0; rb = 0;
        chk(reads == CAPT, "R10 words drained", reads, CAPT);
        chk(!out_ready, "R4 empty after drain", int'(out_ready), 0);

        // Mixed random traffic.
        for (int i = 0; i < 6000; i++) begin
            wa = ($urandom_range(0, 3) != 0); wb = ($urandom_range(0, 4) != 0);
            ra = ($urandom_range(0, 2) != 0); rb = ($urandom_range(0, 5) != 0);
            oe = ($urandom_range(0, 7) != 0);
            wd = W'($urandom);
            @(negedge clk);
        end

        // R7: reset with data inside discards it.
        chk(out_ready, "R7 data held before reset", int'(out_ready), 1);
        rst_n = 0;
        repeat (4) @(negedge clk);
        chk(!in_ready && !out_ready, "R7 flags in reset", int'({in_ready, out_ready}), 0);
        wa = 0; wb = 0; ra = 0; rb = 0; oe = 1;
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk(!out_ready, "R7 nothing left after reset", int'(out_ready), 0);
        wa = 1; wb = 1; wd = 18'h2C3D4;
        @(negedge clk); wa = 0; wb = 0;
        repeat (4) @(negedge clk);
        chk(out_ready && rd_bus == 18'h2C3D4, "R7 R10 first word after reset",
            int'(rd_bus), 'h2C3D4);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule